// File: doc/BRIEF.md
# Update-Based Snooping Coherence Controller

This block keeps a small direct-mapped set of cache lines coherent on a shared snooping bus. It uses an update policy. When another cache writes a word, this controller copies that word into its own copy of the line. It does not drop the line. A line held here is in one of four states: exclusive clean, shared clean, shared owned-dirty, or modified. A line that is absent has no state at all, and no invalid state exists. The processor side offers a simple request/done handshake for one word at a time. The bus side asks an external arbiter for the bus and drives one transaction in each granted cycle. It reads the wired-OR shared line in that same cycle.

The snoop side sees the transactions of the other caches. For each one it answers in the same cycle. It raises a shared indication when it holds the line. It also supplies the full line on a read when it is the owner, meaning the line is shared owned-dirty or modified. Memory is never written by word broadcasts. Only the owner writes data back, and it does so when its line is replaced.

Top module: `dragon_ctl`

## Requirements
- R1: After reset every line is absent. bus_req and cpu_done are low, and no snooped transaction sees snp_hit.
- R2: Bus command codes are 0 none, 1 read, 2 word update and 3 line flush. A command is driven only in a cycle where bus_req and bus_gnt are both high. A read miss issues one read. The line becomes shared clean if bus_shared was high in that cycle, otherwise exclusive clean. The requested word of the fetched line is returned on cpu_rdata.
- R3: A write miss issues a read. If bus_shared is high during that read, a word update follows and the line ends shared owned-dirty. If it is low, no update is issued and the line ends modified with the word merged in.
- R4: A write hit on an exclusive clean or modified line completes with no bus transaction, and the line ends modified.
- R5: A write hit on a shared clean or shared owned-dirty line issues one word update carrying cpu_addr, cpu_widx and cpu_wdata. The line ends shared owned-dirty if bus_shared was high, otherwise modified.
- R6: Snooped reads change the line as follows. An exclusive clean line becomes shared clean without supplying data. A modified line supplies its data and becomes shared owned-dirty. A shared owned-dirty line supplies its data and keeps its state. A shared clean line does not supply data.
- R7: A snooped update that hits writes snp_word into word snp_widx of the local copy and leaves the line shared clean. A snooped update whose tag does not match changes nothing.
- R8: snp_hit is high during a snooped read or update whenever the addressed line is present. snp_supply is high only on a snooped read of an owned line, and snp_line then carries the line's current contents.
- R9: The line index is the low log2(NLINES) bits of the line address. On a miss that evicts an owned line, a flush carrying the old address and the old contents comes before the read. An exclusive clean or shared clean victim is dropped with no bus transaction.
- R10: A pending write to a shared line changes nothing in the local copy until the bus is granted. A snooped read in the meantime is supplied with the old data.
- R11: When a snooped read or update and a new processor request arrive in the same cycle, the snoop is serviced first. The request is then evaluated against the updated state.
- R12: A read hit returns its word with cpu_done high one cycle after the request, with no bus transaction. cpu_done is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | AW | Line address of the request |
| cpu_widx | input | log2(WORDS) | Word within the line |
| cpu_wdata | input | DW | Write data |
| cpu_done | output | 1 | Request complete (one-cycle pulse) |
| cpu_rdata | output | DW | Read data, valid with cpu_done |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus granted this cycle |
| bus_cmd | output | 2 | Command driven in the granted cycle |
| bus_addr | output | AW | Line address of the command |
| bus_widx | output | log2(WORDS) | Word index for an update |
| bus_word | output | DW | Word data for an update |
| bus_line_o | output | WORDS*DW | Line data for a flush |
| bus_line_i | input | WORDS*DW | Line returned for a read |
| bus_shared | input | 1 | Wired-OR shared line, sampled in the granted cycle |
| snp_cmd | input | 2 | Transaction of another cache |
| snp_addr | input | AW | Its line address |
| snp_widx | input | log2(WORDS) | Its word index |
| snp_word | input | DW | Its word data |
| snp_hit | output | 1 | Drives the shared line for this cache |
| snp_supply | output | 1 | This cache supplies the line |
| snp_line | output | WORDS*DW | Supplied line data |

## Verification
A processor request can arrive in the same cycle as a snooped read or update. The bench provokes this by raising a write on an exclusive clean line together with a snooped read of that same line. It then requires that the snoop sees no supply, and that the write then goes out as a bus word update instead of completing silently. A second overlap is a snooped read that lands while this controller's own update waits for the grant. Here the supplied line must still hold the old word, and the new word must appear only after the granted cycle.

// File: rtl/dragon_ctl.sv
module dragon_ctl #(
  parameter int AW     = 8,
  parameter int NLINES = 4,
  parameter int WORDS  = 4,
  parameter int DW     = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_req,
  input  logic                      cpu_we,
  input  logic [AW-1:0]             cpu_addr,
  input  logic [$clog2(WORDS)-1:0]  cpu_widx,
  input  logic [DW-1:0]             cpu_wdata,
  output logic                      cpu_done,
  output logic [DW-1:0]             cpu_rdata,
  output logic                      bus_req,
  input  logic                      bus_gnt,
  output logic [1:0]                bus_cmd,
  output logic [AW-1:0]             bus_addr,
  output logic [$clog2(WORDS)-1:0]  bus_widx,
  output logic [DW-1:0]             bus_word,
  output logic [WORDS*DW-1:0]       bus_line_o,
  input  logic [WORDS*DW-1:0]       bus_line_i,
  input  logic                      bus_shared,
  input  logic [1:0]                snp_cmd,
  input  logic [AW-1:0]             snp_addr,
  input  logic [$clog2(WORDS)-1:0]  snp_widx,
  input  logic [DW-1:0]             snp_word,
  output logic                      snp_hit,
  output logic                      snp_supply,
  output logic [WORDS*DW-1:0]       snp_line
);
  localparam int IW = $clog2(NLINES);
  localparam int WW = $clog2(WORDS);
  localparam int LW = WORDS * DW;
  localparam int TW = AW - IW;

  localparam logic [2:0] LS_NP = 3'd0, LS_E = 3'd1, LS_SC = 3'd2, LS_SM = 3'd3, LS_M = 3'd4;
  localparam logic [1:0] C_NONE = 2'd0, C_RD = 2'd1, C_UPD = 2'd2, C_FL = 2'd3;
  localparam logic [1:0] F_IDLE = 2'd0, F_FLUSH = 2'd1, F_RD = 2'd2, F_UPD = 2'd3;

  logic [NLINES-1:0][2:0] st_q;
  logic [TW-1:0]          tag_q [NLINES];
  logic [LW-1:0]          dat_q [NLINES];
  logic [1:0]             fsm_q;
  logic                   done_q;
  logic [DW-1:0]          rdata_q;

  function automatic logic [LW-1:0] put_word(input logic [LW-1:0] l, input logic [WW-1:0] i,
                                             input logic [DW-1:0] w);
    logic [LW-1:0] r;
    r = l;
    r[int'(i)*DW +: DW] = w;
    return r;
  endfunction

  function automatic logic [DW-1:0] get_word(input logic [LW-1:0] l, input logic [WW-1:0] i);
    return l[int'(i)*DW +: DW];
  endfunction

  logic [IW-1:0] c_idx, s_idx;
  logic [TW-1:0] c_tag, s_tag;
  logic [2:0]    c_st, s_st;
  logic          c_hit, c_owned, s_act, s_hit, go, accept;

  assign c_idx   = cpu_addr[IW-1:0];
  assign c_tag   = cpu_addr[AW-1:IW];
  assign c_st    = st_q[c_idx];
  assign c_hit   = (c_st != LS_NP) && (tag_q[c_idx] == c_tag);
  assign c_owned = (c_st == LS_SM) || (c_st == LS_M);

  assign s_idx = snp_addr[IW-1:0];
  assign s_tag = snp_addr[AW-1:IW];
  assign s_st  = st_q[s_idx];
  assign s_act = (snp_cmd == C_RD) || (snp_cmd == C_UPD);
  assign s_hit = s_act && (s_st != LS_NP) && (tag_q[s_idx] == s_tag);

  assign snp_hit    = s_hit;
  assign snp_supply = s_hit && (snp_cmd == C_RD) && ((s_st == LS_SM) || (s_st == LS_M));
  assign snp_line   = snp_supply ? dat_q[s_idx] : '0;

  assign bus_req = (fsm_q != F_IDLE);
  assign go      = bus_req && bus_gnt;
  assign accept  = (fsm_q == F_IDLE) && cpu_req && !done_q && !s_act;

  always_comb begin
    bus_cmd = C_NONE;
    if (go) begin
      case (fsm_q)
        F_FLUSH: bus_cmd = C_FL;
        F_RD:    bus_cmd = C_RD;
        F_UPD:   bus_cmd = C_UPD;
        default: bus_cmd = C_NONE;
      endcase
    end
  end

  assign bus_addr   = (fsm_q == F_FLUSH) ? {tag_q[c_idx], c_idx} : cpu_addr;
  assign bus_widx   = cpu_widx;
  assign bus_word   = cpu_wdata;
  assign bus_line_o = dat_q[c_idx];

  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      fsm_q   <= F_IDLE;
      done_q  <= 1'b0;
      rdata_q <= '0;
      for (int i = 0; i < NLINES; i++) begin
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      done_q <= 1'b0;

      if (s_hit) begin
        if (snp_cmd == C_RD) begin
          if (s_st == LS_E) st_q[s_idx] <= LS_SC;
          else if (s_st == LS_M) st_q[s_idx] <= LS_SM;
        end else begin
          dat_q[s_idx] <= put_word(dat_q[s_idx], snp_widx, snp_word);
          st_q[s_idx]  <= LS_SC;
        end
      end

      case (fsm_q)
        F_IDLE: if (accept) begin
          if (c_hit) begin
            if (!cpu_we) begin
              rdata_q <= get_word(dat_q[c_idx], cpu_widx);
              done_q  <= 1'b1;
            end else if ((c_st == LS_E) || (c_st == LS_M)) begin
              dat_q[c_idx] <= put_word(dat_q[c_idx], cpu_widx, cpu_wdata);
              st_q[c_idx]  <= LS_M;
              done_q       <= 1'b1;
            end else begin
              fsm_q <= F_UPD;
            end
          end else begin
            fsm_q <= c_owned ? F_FLUSH : F_RD;
          end
        end
        F_FLUSH: if (go) begin
          st_q[c_idx] <= LS_NP;
          fsm_q       <= F_RD;
        end
        F_RD: if (go) begin
          tag_q[c_idx] <= c_tag;
          if (!cpu_we) begin
            dat_q[c_idx] <= bus_line_i;
            st_q[c_idx]  <= bus_shared ? LS_SC : LS_E;
            rdata_q      <= get_word(bus_line_i, cpu_widx);
            done_q       <= 1'b1;
            fsm_q        <= F_IDLE;
          end else if (bus_shared) begin
            dat_q[c_idx] <= bus_line_i;
            st_q[c_idx]  <= LS_SC;
            fsm_q        <= F_UPD;
          end else begin
            dat_q[c_idx] <= put_word(bus_line_i, cpu_widx, cpu_wdata);
            st_q[c_idx]  <= LS_M;
            done_q       <= 1'b1;
            fsm_q        <= F_IDLE;
          end
        end
        F_UPD: if (go) begin
          dat_q[c_idx] <= put_word(dat_q[c_idx], cpu_widx, cpu_wdata);
          st_q[c_idx]  <= bus_shared ? LS_SM : LS_M;
          done_q       <= 1'b1;
          fsm_q        <= F_IDLE;
        end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dragon_ctl_chk.sv
module dragon_ctl_chk #(
  parameter int AW     = 8,
  parameter int NLINES = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_req,
  input logic                   bus_gnt,
  input logic [1:0]             bus_cmd,
  input logic [1:0]             snp_cmd,
  input logic [AW-1:0]          snp_addr,
  input logic                   snp_hit,
  input logic                   snp_supply,
  input logic                   cpu_done,
  input logic [NLINES-1:0][2:0] st
);
  localparam int IW = $clog2(NLINES);

  p_cmd_needs_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != 2'd0) |-> (bus_req && bus_gnt));

  p_supply_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> (snp_hit && snp_cmd == 2'd1));

  p_update_to_shared_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_cmd == 2'd2 && snp_hit) |=> (st[$past(snp_addr[IW-1:0])] == 3'd2));

  p_supplier_keeps_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |=> (st[$past(snp_addr[IW-1:0])] == 3'd3));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
endmodule

bind dragon_ctl dragon_ctl_chk #(.AW(AW), .NLINES(NLINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
  .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_hit(snp_hit), .snp_supply(snp_supply),
  .cpu_done(cpu_done), .st(st_q)
);

// File: tb/dragon_ctl_test.sv
`timescale 1ns/1ps
module dragon_ctl_test;
  localparam int AW = 8, NL = 4, WD = 4, DW = 16, LW = 64;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [1:0] cpu_widx = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_done;
  logic [DW-1:0] cpu_rdata;
  logic bus_req, bus_gnt = 0, bus_shared = 0;
  logic [1:0] bus_cmd, bus_widx;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_word;
  logic [LW-1:0] bus_line_o, bus_line_i = '0;
  logic [1:0] snp_cmd = 0, snp_widx = 0;
  logic [AW-1:0] snp_addr = '0;
  logic [DW-1:0] snp_word = '0;
  logic snp_hit, snp_supply;
  logic [LW-1:0] snp_line;

  dragon_ctl #(.AW(AW), .NLINES(NL), .WORDS(WD), .DW(DW)) uut (.*);

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  logic [1:0]    lg_cmd [8];
  logic [AW-1:0] lg_addr [8];
  logic [1:0]    lg_widx [8];
  logic [DW-1:0] lg_word [8];
  logic [LW-1:0] lg_line [8];
  int nlog, ncyc;
  logic [DW-1:0] rd;
  logic h, s;
  logic [LW-1:0] sl;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: act %0d cycles exp completion", cyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic finish_op(input logic shr, input logic [LW-1:0] line);
    logic fin;
    fin = 0; ncyc = 0; nlog = 0;
    while (!fin && ncyc < 50) begin
      @(negedge clk);
      ncyc++;
      bus_gnt = 0;
      if (cpu_done) begin
        fin = 1; rd = cpu_rdata; cpu_req = 0;
      end else begin
        bus_gnt = bus_req; bus_shared = shr; bus_line_i = line;
        #1;
        if (bus_gnt && nlog < 8) begin
          lg_cmd[nlog] = bus_cmd; lg_addr[nlog] = bus_addr; lg_widx[nlog] = bus_widx;
          lg_word[nlog] = bus_word; lg_line[nlog] = bus_line_o; nlog++;
        end
      end
    end
    cpu_req = 0; bus_gnt = 0;
  endtask

  task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [1:0] w,
                        input logic [DW-1:0] d, input logic shr, input logic [LW-1:0] line);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_widx = w; cpu_wdata = d;
    finish_op(shr, line);
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, input logic [1:0] w,
                       input logic [DW-1:0] d);
    @(negedge clk);
    snp_cmd = c; snp_addr = a; snp_widx = w; snp_word = d;
    #1; h = snp_hit; s = snp_supply; sl = snp_line;
    @(negedge clk);
    snp_cmd = 0;
  endtask

  logic [LW-1:0] e10;

  task automatic t_reset();
    chk("R1 bus_req after reset", bus_req, 0);
    chk("R1 cpu_done after reset", cpu_done, 0);
    snoop(1, 8'h10, 0, 0);
    chk("R1 no line present", h, 0);
  endtask

  task automatic t_read_miss_and_silent_writes();
    e10 = 64'h1111_2222_3333_4444;
    cpu_op(0, 8'h10, 1, 0, 0, e10);
    chk("R2 read miss one txn", nlog, 1);
    chk("R2 read miss cmd", lg_cmd[0], 1);
    chk("R2 read miss addr", lg_addr[0], 8'h10);
    chk("R2 read miss data", rd, 16'h3333);
    cpu_op(1, 8'h10, 0, 16'hA001, 0, '0);
    chk("R4 write hit exclusive no bus", nlog, 0);
    e10[15:0] = 16'hA001;
    cpu_op(1, 8'h10, 3, 16'hA002, 0, '0);
    chk("R4 write hit modified no bus", nlog, 0);
    e10[63:48] = 16'hA002;
    snoop(1, 8'h10, 0, 0);
    chk("R6 modified supplies", s, 1);
    chk("R6 modified supplied line", sl, e10);
    snoop(1, 8'h10, 0, 0);
    chk("R6 owner keeps supplying", s, 1);
    chk("R8 hit on read snoop", h, 1);
  endtask

  task automatic t_read_hit();
    cpu_op(0, 8'h10, 0, 0, 0, '0);
    chk("R12 read hit latency", ncyc, 1);
    chk("R12 read hit no bus", nlog, 0);
    chk("R12 read hit data", rd, 16'hA001);
  endtask

  task automatic t_snoop_update();
    snoop(2, 8'h10, 2, 16'hBEEF);
    chk("R8 hit on update snoop", h, 1);
    chk("R8 no supply on update", s, 0);
    e10[47:32] = 16'hBEEF;
    snoop(1, 8'h10, 0, 0);
    chk("R7 owner became shared clean", s, 0);
    chk("R6 shared clean still hits", h, 1);
    cpu_op(0, 8'h10, 2, 0, 0, '0);
    chk("R7 word applied", rd, 16'hBEEF);
    snoop(2, 8'h20, 3, 16'hDEAD);
    chk("R7 tag mismatch no hit", h, 0);
    cpu_op(0, 8'h10, 3, 0, 0, '0);
    chk("R7 tag mismatch ignored", rd, 16'hA002);
  endtask

  task automatic t_shared_write_hits();
    cpu_op(1, 8'h10, 1, 16'hC001, 0, '0);
    chk("R5 update issued", nlog, 1);
    chk("R5 update cmd", lg_cmd[0], 2);
    chk("R5 update addr", lg_addr[0], 8'h10);
    chk("R5 update widx", lg_widx[0], 1);
    chk("R5 update word", lg_word[0], 16'hC001);
    e10[31:16] = 16'hC001;
    snoop(1, 8'h10, 0, 0);
    chk("R5 unshared write made owner", s, 1);
    chk("R5 line after write", sl, e10);
    cpu_op(1, 8'h10, 2, 16'hC002, 1, '0);
    chk("R5 owner write updates", nlog, 1);
    chk("R5 owner write cmd", lg_cmd[0], 2);
    e10[47:32] = 16'hC002;
    snoop(1, 8'h10, 0, 0);
    chk("R5 shared write stays owner", s, 1);
    chk("R5 owner line", sl, e10);
  endtask

  task automatic t_replacement();
    cpu_op(0, 8'h20, 0, 0, 1, 64'h5555_6666_7777_8888);
    chk("R9 flush then read", nlog, 2);
    chk("R9 flush cmd", lg_cmd[0], 3);
    chk("R9 flush addr", lg_addr[0], 8'h10);
    chk("R9 flush line", lg_line[0], e10);
    chk("R9 read after flush", lg_cmd[1], 1);
    chk("R9 read addr", lg_addr[1], 8'h20);
    chk("R2 shared read data", rd, 16'h8888);
    cpu_op(0, 8'h30, 0, 0, 0, 64'h9999_AAAA_BBBB_CCCC);
    chk("R9 clean victim silent", nlog, 1);
    chk("R9 silent victim read", lg_cmd[0], 1);
    snoop(1, 8'h20, 0, 0);
    chk("R9 victim gone", h, 0);
    snoop(1, 8'h10, 0, 0);
    chk("R9 flushed victim gone", h, 0);
  endtask

  task automatic t_write_misses();
    cpu_op(1, 8'h05, 2, 16'hD005, 0, 64'h0123_4567_89AB_CDEF);
    chk("R3 unshared write miss one read", nlog, 1);
    chk("R3 write miss read cmd", lg_cmd[0], 1);
    snoop(1, 8'h05, 0, 0);
    chk("R3 unshared write miss modified", s, 1);
    chk("R3 merged line", sl, 64'h0123_D005_89AB_CDEF);
    cpu_op(1, 8'h06, 3, 16'hD006, 1, 64'hFEDC_BA98_7654_3210);
    chk("R3 shared write miss two txns", nlog, 2);
    chk("R3 shared first read", lg_cmd[0], 1);
    chk("R3 shared then update", lg_cmd[1], 2);
    chk("R3 update word", lg_word[1], 16'hD006);
    snoop(1, 8'h06, 0, 0);
    chk("R3 shared write miss owner", s, 1);
    chk("R3 owner line", sl, 64'hD006_BA98_7654_3210);
  endtask

  task automatic t_no_early_update();
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = 8'h06; cpu_widx = 0; cpu_wdata = 16'hD009;
    @(negedge clk);
    chk("R10 waiting for grant", bus_req, 1);
    snp_cmd = 1; snp_addr = 8'h06;
    #1;
    chk("R10 old data supplied", snp_line, 64'hD006_BA98_7654_3210);
    @(negedge clk);
    snp_cmd = 0; bus_gnt = 1; bus_shared = 1;
    #1;
    chk("R10 update at grant", bus_cmd, 2);
    chk("R10 update word", bus_word, 16'hD009);
    @(negedge clk);
    bus_gnt = 0;
    chk("R10 done after grant", cpu_done, 1);
    cpu_req = 0;
    snoop(1, 8'h06, 0, 0);
    chk("R10 new data after grant", sl, 64'hD006_BA98_7654_D009);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = 8'h30; cpu_widx = 1; cpu_wdata = 16'hD010;
    snp_cmd = 1; snp_addr = 8'h30;
    #1;
    chk("R11 snoop sees line", snp_hit, 1);
    chk("R11 exclusive does not supply", snp_supply, 0);
    @(negedge clk);
    snp_cmd = 0;
    chk("R11 request deferred", cpu_done, 0);
    finish_op(1, '0);
    chk("R11 write goes to bus", nlog, 1);
    chk("R11 update cmd", lg_cmd[0], 2);
    snoop(1, 8'h30, 0, 0);
    chk("R11 ends owner", s, 1);
    chk("R11 line", sl, 64'h9999_AAAA_D010_CCCC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read_miss_and_silent_writes();
    t_read_hit();
    t_snoop_update();
    t_shared_write_hits();
    t_replacement();
    t_write_misses();
    t_no_early_update();
    t_same_cycle();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule